// File: doc/BRIEF.md
# Three-Bit Framed Sequence Recognizer

This block watches a one-bit serial stream and splits it into back-to-back groups of three bits. The first group starts at the first clock edge after reset is released. On the last bit of each group, the block raises its output if the middle bit was 1 and the last bit is 0. The first bit of a group never changes the result. Once a group ends, the next bit always opens a new group, so a match never overlaps two groups.

The machine has four states: an idle state that waits for the first bit, one state that holds "first bit seen", and two states that record the value of the middle bit. The output is a Mealy output: it is decoded from the state and the present input bit, so it is valid during the same cycle as the final bit of the group. A synchronous reset brings the group alignment back to the start.

Top module: `frame_recognizer`

## Requirements
- R1: While `rst` is high at a rising edge, the state returns to idle (encoding 2'b00). While `rst` is high, `z_o` is 0.
- R2: The first bit of a group has no effect. Groups 010 and 110 give the same result, and so do groups 000 and 100.
- R3: `z_o` is 0 during the first and second bit of every group.
- R4: During the third bit of a group, `z_o` is 1 exactly when the second bit was 1 and the present bit is 0.
- R5: Groups do not overlap. The bit after a group's third bit is always the first bit of a new group, even when the last bits seen would form 1-then-0 across the boundary.
- R6: A reset raised partway through a group discards that group. This takes priority over `x_i`, and the bit after reset is released is the first bit of a new group.
- R7: `z_o` follows `x_i` within the third-bit cycle with no clock edge in between. Changing `x_i` after the middle bit was 1 toggles `z_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x_i | input | 1 | Serial input bit, one per cycle |
| z_o | output | 1 | Match flag, valid in the third-bit cycle |

## Verification
Two things can happen in the same cycle: a match decision and a reset. The hardest case is reset asserted during a third-bit cycle whose middle bit was 1 and whose present bit is 0. The bench creates this cycle on purpose. It expects `z_o` to stay 0 and expects the next bit to start a fresh group. A behavioural model that counts bit positions judges every cycle, including a mid-cycle toggle of `x_i` that exercises the combinational output path.

// File: rtl/frame_pkg.sv
package frame_pkg;
  localparam int unsigned ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 2'b00,
    ST_FIRST = 2'b01,
    ST_MID0  = 2'b10,
    ST_MID1  = 2'b11
  } frame_st_e;
endpackage

// File: rtl/frame_next.sv
module frame_next
  import frame_pkg::*;
(
  input  frame_st_e cur_i,
  input  logic      x_i,
  output frame_st_e nxt_o,
  output logic      hit_o
);
  always_comb begin
    nxt_o = ST_IDLE;
    hit_o = 1'b0;
    case (cur_i)
      ST_IDLE:  nxt_o = ST_FIRST;
      ST_FIRST: nxt_o = x_i ? ST_MID1 : ST_MID0;
      ST_MID0:  nxt_o = ST_IDLE;
      ST_MID1: begin
        nxt_o = ST_IDLE;
        hit_o = ~x_i;
      end
      default:  nxt_o = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/frame_state_reg.sv
module frame_state_reg
  import frame_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  frame_st_e nxt_i,
  output frame_st_e cur_o
);
  always_ff @(posedge clk) begin
    if (rst) cur_o <= ST_IDLE;
    else     cur_o <= nxt_i;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cur_o == ST_IDLE);

  // R5
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_o == ST_MID0 || cur_o == ST_MID1) |=> cur_o == ST_IDLE);

  // R2
  first_merge_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_o == ST_IDLE) |=> cur_o == ST_FIRST);
endmodule

// File: rtl/frame_recognizer.sv
module frame_recognizer
  import frame_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x_i,
  output logic z_o
);
  frame_st_e cur;
  frame_st_e nxt;
  logic      hit;

  frame_next u_next (
    .cur_i (cur),
    .x_i   (x_i),
    .nxt_o (nxt),
    .hit_o (hit)
  );

  frame_state_reg u_reg (
    .clk   (clk),
    .rst   (rst),
    .nxt_i (nxt),
    .cur_o (cur)
  );

  assign z_o = hit & ~rst;

  // R3
  hit_only_last_chk: assert property (@(posedge clk) disable iff (rst)
    z_o |-> (cur == ST_MID1));

  // R4
  middle_one_chk: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_MID0) |-> !z_o);

  // R4
  mid1_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_MID1 && x_i) |-> !z_o);
endmodule

// File: tb/test_frame_recognizer.sv
module test_frame_recognizer;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  logic z;

  int total = 0;
  int bad   = 0;
  int pos   = 0;
  bit mid   = 1'b0;

  frame_recognizer i_frame_recognizer (
    .clk (clk),
    .rst (rst),
    .x_i (x),
    .z_o (z)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic model_z(input logic rv, input logic xv);
    return (!rv && pos == 2 && mid && !xv);
  endfunction

  task automatic chk(input string tag, input logic exp);
    total++;
    if (z !== exp) begin
      bad++;
      $display("FAIL %s z actual=%0b expected=%0b", tag, z, exp);
    end
  endtask

  task automatic step(input logic xv, input logic rv);
    string tag;
    @(negedge clk);
    x = xv;
    rst = rv;
    #1;
    if (rv)            tag = "R1";
    else if (pos == 2) tag = "R4";
    else if (pos == 1) tag = "R3";
    else               tag = "R2";
    chk(tag, model_z(rv, xv));
    if (rv) pos = 0;
    else begin
      if (pos == 1) mid = xv;
      pos = (pos + 1) % 3;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    // R2: first bit ignored, 010 and 110 both match
    step(0,0); step(1,0); step(0,0);
    step(1,0); step(1,0); step(0,0);
    // R2: 000 and 100 do not match
    step(0,0); step(0,0); step(0,0);
    step(1,0); step(0,0); step(0,0);
    // R3/R4: 011 and 111 miss
    step(0,0); step(1,0); step(1,0);
    step(1,0); step(1,0); step(1,0);
    // R5: 1,1 | 0,... boundary pattern must not fire
    step(0,0); step(0,0); step(1,0);
    step(1,0); step(0,0); step(0,0);
    // R6: reset mid-frame then realign
    step(1,0); step(1,1); step(1,0); step(1,0); step(0,0);
    // R6 + R4: reset in a matching third-bit cycle wins
    step(0,0); step(1,0); step(0,1);
    step(0,0); step(1,0); step(0,0);
    // R7: z follows x inside the third-bit cycle
    step(0,0); step(1,0);
    @(negedge clk);
    rst = 1'b0;
    x = 1'b0;
    #1 chk("R7", 1'b1);
    x = 1'b1;
    #1 chk("R7", 1'b0);
    x = 1'b0;
    #1 chk("R7", 1'b1);
    pos = 0;
    // Mixed traffic with occasional reset
    for (int i = 0; i < 600; i++) begin
      logic rr;
      rr = (($urandom % 23) == 0);
      step(1'($urandom), rr);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule